// File: doc/BRIEF.md
# Nibble-Wide Display Fetch Controller

This block fetches display bytes from a DRAM array built from four 1-bit devices that share one multiplexed address bus. Each byte therefore needs two 4-bit column reads under one row strobe. A free-running 8-phase slot sequences the row strobe, the column strobe and the address bus. The block joins the two nibbles into one byte and raises a one-cycle ready flag when the byte is complete.

The block also tracks the screen address through a character-cell layout. Within one scanline, consecutive bytes lie 8 apart. The next scanline of a character row starts one byte after the previous line start. After the eighth line, the address moves back by 7, which places it at the first line of the next character row. Addresses that run past the top of the 32 KiB screen area wrap back by the screen size. The screen start and the screen size follow from a 3-bit display mode.

The surrounding video timing supplies three signals. `frame_start` reloads the screen start, `line_start` marks each new scanline, and `pix_window` marks the pixel window. `cpu_hold` blocks any fetch that has not yet started.

Top module: `nibble_fetch_ctrl`

## Requirements
- R1: `slot_phase` is 0 in the first cycle after reset and counts 0,1,...,7,0 without stopping, one step per clock.
- R2: A slot is active when its fetch is granted. In an active slot, `ram_addr` carries screen address bits [15:7] in phase 0. In phases 1 to 3 it carries the column {addr[6:0],0}, and in phases 4 to 7 the column {addr[6:0],1}, where addr is the address latched at the end of phase 0. `ras_n` is low in phases 1 to 6, and `cas_n` is low in phases 2, 3, 5 and 6. In an idle slot both strobes stay high and `ram_addr` is 0.
- R3: In an active slot, `ram_din` sampled in phase 3 becomes `byte_out`[7:4] and `ram_din` sampled in phase 6 becomes `byte_out`[3:0]. `byte_rdy` is high only in the phase-7 cycle of an active slot. `byte_out` holds its value until the next byte.
- R4: A slot is granted only if, in its phase 0, four conditions all hold: the access divider is 0, `pix_window` is 1, the current line is not a spacing line, and `cpu_hold` is 0.
- R5: The access divider is 0 after reset and advances at the end of every phase 7. It counts modulo 1 in modes 0 to 3, which use 80 bytes per line, and modulo 2 in modes 4 to 6, which use 40 bytes per line.
- R6: Each granted fetch adds 8 to `scr_addr`, and the new value is visible from phase 7. A sum of 0x8000 or more has the screen size subtracted from it.
- R7: On a `line_start` pulse that stays inside a character row, `scr_addr` and the stored line start both become the previous line start plus 1, wrapped as in R6.
- R8: On the `line_start` pulse that ends the eighth line of a row, `scr_addr` becomes `scr_addr` minus 7, and that value also becomes the new line start.
- R9: In the 25-row modes (3 and 6), the two `line_start` pulses after each row end only mark spacing lines, and no fetch is granted on those lines. The following pulse then begins line 0 of the new row without moving the address.
- R10: Reset or `frame_start` loads `scr_addr` and the line start with the screen start and clears the line and spacing counts. The screen start is 0x8000 minus rows*bytes_per_line*8, rounded down to a multiple of 256. This gives 0x3000 for modes 0, 1 and 2, 0x4100 for mode 3, 0x5800 for modes 4 and 5, and 0x6000 for mode 6. Priority is `frame_start`, then `line_start`, then the fetch step.
- R11: Mode code 7 behaves exactly like mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Display mode 0..7 |
| frame_start | input | 1 | One-cycle pulse: reload screen start |
| line_start | input | 1 | One-cycle pulse: next scanline begins |
| pix_window | input | 1 | Beam is inside the pixel window |
| cpu_hold | input | 1 | Blocks fetches that have not started |
| ram_din | input | 4 | Nibble read from the DRAM devices |
| ram_addr | output | 9 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| slot_phase | output | 3 | Current phase of the 8-phase slot |
| byte_out | output | 8 | Last assembled byte |
| byte_rdy | output | 1 | One-cycle flag: new byte in `byte_out` |
| scr_addr | output | 16 | Current screen address |

## Verification
The strobes and `ram_addr` change in the same cycle as `slot_phase`. The phase-0 grant also depends on that cycle's `pix_window` and `cpu_hold`. The byte and `byte_rdy` appear one edge after the phase-6 capture, in phase 7, and the 8-byte step is visible from that same cycle. The `frame_start` and `line_start` pulses take effect at the next edge. The bench applies each cycle's inputs at the falling edge and compares shortly afterwards against a behavioural model, then advances that model at the rising edge. Because of this ordering, every result is compared in the exact cycle in which it is due. Two long single-line runs drive the address across the 0x8000 boundary in a 25-row mode at both divider rates.

// File: rtl/nfc_pkg.sv
// Shared definitions for the nibble-wide display fetch controller.
// Assumes mode codes 0..6; code 7 is treated as mode 6.
package nfc_pkg;

    localparam int unsigned FULL_LINE_BYTES = 80;

    typedef enum logic [2:0] {
        PH_ROW    = 3'd0,
        PH_RAS    = 3'd1,
        PH_CAS_HI = 3'd2,
        PH_CAP_HI = 3'd3,
        PH_COL_LO = 3'd4,
        PH_CAS_LO = 3'd5,
        PH_CAP_LO = 3'd6,
        PH_IDLE   = 3'd7
    } phase_e;

    // Horizontal resolution of each mode in pixels.
    function automatic int unsigned mode_width(input logic [2:0] m);
        case (m)
            3'd0, 3'd3:             return 640;
            3'd1, 3'd4, 3'd6, 3'd7: return 320;
            default:                return 160;
        endcase
    endfunction

    // Bits per pixel of each mode.
    function automatic int unsigned mode_bpp(input logic [2:0] m);
        case (m)
            3'd1, 3'd5: return 2;
            3'd2:       return 4;
            default:    return 1;
        endcase
    endfunction

    // Character rows on screen.
    function automatic int unsigned mode_rows(input logic [2:0] m);
        return (m == 3'd3 || m >= 3'd6) ? 25 : 32;
    endfunction

    function automatic int unsigned line_bytes(input logic [2:0] m);
        return (mode_width(m) * mode_bpp(m)) / 8;
    endfunction

    // Slots per fetch: 1 for 80-byte lines, 2 for 40-byte lines.
    function automatic int unsigned fetch_period(input logic [2:0] m);
        return FULL_LINE_BYTES / line_bytes(m);
    endfunction

    function automatic logic row_spaced(input logic [2:0] m);
        return mode_rows(m) != 32;
    endfunction

    // Screen start: top of screen area minus footprint, rounded down to 256.
    function automatic int unsigned screen_start(input logic [2:0] m,
                                                 input int unsigned lines_per_row,
                                                 input int unsigned limit);
        int unsigned span;
        span = mode_rows(m) * line_bytes(m) * lines_per_row;
        return (limit - span) & ~32'd255;
    endfunction

endpackage

// File: rtl/nfc_slot_seq.sv
// Slot sequencer: runs the 8-phase slot, decides in phase 0 whether the
// slot fetches, and drives strobes and the multiplexed address bus.
// Assumes scr_addr is stable during phase 0 of each slot.
module nfc_slot_seq #(
    parameter int ADDR_W   = 16,
    parameter int COL_BITS = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 mode,
    input  logic                       pix_window,
    input  logic                       cpu_hold,
    input  logic                       blank_line,
    input  logic [ADDR_W-1:0]          scr_addr,
    output logic [ADDR_W-COL_BITS-1:0] ram_addr,
    output logic                       ras_n,
    output logic                       cas_n,
    output logic [2:0]                 phase,
    output logic                       hi_cap,
    output logic                       lo_cap,
    output logic                       step
);
    import nfc_pkg::*;

    localparam int ROW_W = ADDR_W - COL_BITS;

    phase_e            ph;
    logic              act_q;
    logic              act;
    logic              go;
    logic [1:0]        div;
    logic [1:0]        period;
    logic [ADDR_W-1:0] lat;
    logic [ROW_W-1:0]  col_even;
    logic [ROW_W-1:0]  col_odd;

    assign period   = 2'(fetch_period(mode));
    assign go       = (ph == PH_ROW) && (div == 2'd0) && pix_window && !cpu_hold && !blank_line;
    assign act      = (ph == PH_ROW) ? go : act_q;
    assign col_even = ROW_W'({lat[COL_BITS-1:0], 1'b0});
    assign col_odd  = ROW_W'({lat[COL_BITS-1:0], 1'b1});

    // Phase counter, per-slot grant and address latch, access divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_ROW;
            act_q <= 1'b0;
            lat   <= '0;
            div   <= 2'd0;
        end else begin
            ph <= phase_e'(ph + 3'd1);
            if (ph == PH_ROW) begin
                act_q <= go;
                lat   <= scr_addr;
            end
            if (ph == PH_IDLE)
                div <= (div + 2'd1 >= period) ? 2'd0 : div + 2'd1;
        end
    end

    // Strobe and address bus decode for the current phase.
    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        ram_addr = '0;
        if (act) begin
            case (ph)
                PH_ROW:    ram_addr = scr_addr[ADDR_W-1:COL_BITS];
                PH_RAS:    begin ras_n = 1'b0; ram_addr = col_even; end
                PH_CAS_HI,
                PH_CAP_HI: begin ras_n = 1'b0; cas_n = 1'b0; ram_addr = col_even; end
                PH_COL_LO: begin ras_n = 1'b0; ram_addr = col_odd; end
                PH_CAS_LO,
                PH_CAP_LO: begin ras_n = 1'b0; cas_n = 1'b0; ram_addr = col_odd; end
                default:   ram_addr = col_odd;
            endcase
        end
    end

    assign phase  = ph;
    assign hi_cap = act && (ph == PH_CAP_HI);
    assign lo_cap = act && (ph == PH_CAP_LO);
    assign step   = lo_cap;

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase == 3'($past(phase) + 3'd1));
    p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    p_hold_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && cpu_hold) |=> ras_n);
    p_blank_no_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && blank_line) |=> ras_n);

endmodule

// File: rtl/nfc_addr_walk.sv
// Address walker: steps the screen address through the character-cell
// layout, handles row ends, spacing lines and wrap at the screen top.
// Assumes line_start and frame_start are single-cycle pulses.
module nfc_addr_walk #(
    parameter int ADDR_W        = 16,
    parameter int LINES_PER_ROW = 8,
    parameter int BLANK_LINES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              step,
    output logic [ADDR_W-1:0] scr_addr,
    output logic              blank_line
);
    import nfc_pkg::*;

    localparam int unsigned      LIMIT = 1 << (ADDR_W - 1);
    localparam logic [ADDR_W:0]  LIM_X = (ADDR_W+1)'(LIMIT);
    localparam int               LW    = $clog2(LINES_PER_ROW);
    localparam int               SW    = $clog2(BLANK_LINES + 1);

    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] ls;
    logic [LW-1:0]     line;
    logic [SW-1:0]     spc;
    logic [ADDR_W-1:0] start_w;
    logic [ADDR_W-1:0] size_w;
    logic [ADDR_W-1:0] next_line;
    logic [ADDR_W-1:0] back_row;
    logic [ADDR_W-1:0] next_byte;

    // Fold an address that reached the screen top back by the screen size.
    function automatic logic [ADDR_W-1:0] wrap_ad(input logic [ADDR_W:0] v,
                                                  input logic [ADDR_W-1:0] sz);
        if (v >= LIM_X)
            return ADDR_W'(v - {1'b0, sz});
        return v[ADDR_W-1:0];
    endfunction

    assign start_w   = ADDR_W'(screen_start(mode, LINES_PER_ROW, LIMIT));
    assign size_w    = ADDR_W'(LIMIT) - start_w;
    assign next_line = wrap_ad({1'b0, ls} + (ADDR_W+1)'(1), size_w);
    assign back_row  = wrap_ad({1'b0, addr} - (ADDR_W+1)'(LINES_PER_ROW - 1), size_w);
    assign next_byte = wrap_ad({1'b0, addr} + (ADDR_W+1)'(LINES_PER_ROW), size_w);

    // Frame reload, scanline advance and per-byte step, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            addr <= start_w;
            ls   <= start_w;
            line <= '0;
            spc  <= '0;
        end else if (line_start) begin
            if (spc != '0) begin
                spc <= spc - SW'(1);
            end else if (line != LW'(LINES_PER_ROW - 1)) begin
                line <= line + LW'(1);
                addr <= next_line;
                ls   <= next_line;
            end else begin
                line <= '0;
                addr <= back_row;
                ls   <= back_row;
                if (row_spaced(mode))
                    spc <= SW'(BLANK_LINES);
            end
        end else if (step) begin
            addr <= next_byte;
        end
    end

    assign scr_addr   = addr;
    assign blank_line = (spc != '0);

    p_addr_below_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scr_addr < ADDR_W'(LIMIT));
    p_frame_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !blank_line);

endmodule

// File: rtl/nibble_fetch_ctrl.sv
// Top of the nibble-wide display fetch controller: joins the slot
// sequencer and the address walker and assembles bytes from two nibbles.
// Assumes the DRAM returns valid data in the capture phases.
module nibble_fetch_ctrl #(
    parameter int ADDR_W        = 16,
    parameter int COL_BITS      = 7,
    parameter int NIB_W         = 4,
    parameter int LINES_PER_ROW = 8,
    parameter int BLANK_LINES   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 mode_sel,
    input  logic                       frame_start,
    input  logic                       line_start,
    input  logic                       pix_window,
    input  logic                       cpu_hold,
    input  logic [NIB_W-1:0]           ram_din,
    output logic [ADDR_W-COL_BITS-1:0] ram_addr,
    output logic                       ras_n,
    output logic                       cas_n,
    output logic [2:0]                 slot_phase,
    output logic [2*NIB_W-1:0]         byte_out,
    output logic                       byte_rdy,
    output logic [ADDR_W-1:0]          scr_addr
);
    logic             hi_cap;
    logic             lo_cap;
    logic             step;
    logic             blank_line;
    logic [NIB_W-1:0] hi_nib;

    nfc_slot_seq #(.ADDR_W(ADDR_W), .COL_BITS(COL_BITS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_sel),
        .pix_window (pix_window),
        .cpu_hold   (cpu_hold),
        .blank_line (blank_line),
        .scr_addr   (scr_addr),
        .ram_addr   (ram_addr),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .phase      (slot_phase),
        .hi_cap     (hi_cap),
        .lo_cap     (lo_cap),
        .step       (step)
    );

    nfc_addr_walk #(
        .ADDR_W(ADDR_W), .LINES_PER_ROW(LINES_PER_ROW), .BLANK_LINES(BLANK_LINES)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_sel),
        .frame_start (frame_start),
        .line_start  (line_start),
        .step        (step),
        .scr_addr    (scr_addr),
        .blank_line  (blank_line)
    );

    // Byte assembly: high nibble first, then low nibble and ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_nib   <= '0;
            byte_out <= '0;
            byte_rdy <= 1'b0;
        end else begin
            byte_rdy <= lo_cap;
            if (hi_cap)
                hi_nib <= ram_din;
            if (lo_cap)
                byte_out <= {hi_nib, ram_din};
        end
    end

    p_rdy_in_last_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rdy |-> slot_phase == 3'd7);
    p_byte_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_rdy |=> (byte_rdy || $stable(byte_out)));

endmodule

// File: tb/nibble_fetch_ctrl_tb.sv
// Cycle-by-cycle reference model bench for nibble_fetch_ctrl.
module nibble_fetch_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd6;
    logic       frame_start = 1'b0;
    logic       line_start = 1'b0;
    logic       pix_window = 1'b0;
    logic       cpu_hold = 1'b0;
    logic [3:0] ram_din = 4'd0;
    logic [8:0] ram_addr;
    logic       ras_n, cas_n, byte_rdy;
    logic [2:0] slot_phase;
    logic [7:0] byte_out;
    logic [15:0] scr_addr;

    int vectors = 0;
    int errors = 0;
    bit hold_noise = 0;

    // model state
    int m_ph, m_actq, m_lat, m_div, m_addr, m_ls, m_line, m_spc, m_hi, m_byte, m_rdy;

    always #2 clk = ~clk;

    nibble_fetch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .frame_start(frame_start),
        .line_start(line_start), .pix_window(pix_window), .cpu_hold(cpu_hold),
        .ram_din(ram_din), .ram_addr(ram_addr), .ras_n(ras_n), .cas_n(cas_n),
        .slot_phase(slot_phase), .byte_out(byte_out), .byte_rdy(byte_rdy),
        .scr_addr(scr_addr)
    );

    function automatic int m_mode(); return (mode_sel == 3'd7) ? 6 : int'(mode_sel); endfunction
    function automatic int m_bytes();
        int w, b;
        case (m_mode())
            0, 3: w = 640; 1, 4, 6: w = 320; default: w = 160;
        endcase
        case (m_mode())
            1, 5: b = 2; 2: b = 4; default: b = 1;
        endcase
        return w * b / 8;
    endfunction
    function automatic int m_rows(); return (m_mode() == 3 || m_mode() == 6) ? 25 : 32; endfunction
    function automatic int m_start(); return (32768 - m_rows() * m_bytes() * 8) / 256 * 256; endfunction
    function automatic int m_wrap(int v); return (v >= 32768) ? v - (32768 - m_start()) : v; endfunction
    function automatic int m_act();
        if (m_ph != 0) return m_actq;
        return (m_div == 0 && pix_window && !cpu_hold && m_spc == 0) ? 1 : 0;
    endfunction

    task automatic model_reset();
        m_ph = 0; m_actq = 0; m_lat = 0; m_div = 0; m_hi = 0; m_byte = 0; m_rdy = 0;
        m_addr = m_start(); m_ls = m_addr; m_line = 0; m_spc = 0;
    endtask

    task automatic chk(string req, string what, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got 0x%0h exp 0x%0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare all outputs against the model for the current cycle.
    task automatic compare();
        int a, ea, er, ec;
        a = m_act();
        er = 1; ec = 1; ea = 0;
        if (a != 0) begin
            if (m_ph == 0) ea = m_addr / 128;
            else if (m_ph <= 3) ea = (m_lat % 128) * 2;
            else ea = (m_lat % 128) * 2 + 1;
            if (m_ph >= 1 && m_ph <= 6) er = 0;
            if (m_ph == 2 || m_ph == 3 || m_ph == 5 || m_ph == 6) ec = 0;
        end
        chk("R1", "slot_phase", int'(slot_phase), m_ph);
        chk("R2/R4", "ras_n", int'(ras_n), er);   // R2 strobes, R4 grant, R9 blank lines
        chk("R2", "cas_n", int'(cas_n), ec);
        chk("R2", "ram_addr", int'(ram_addr), ea);
        chk("R3", "byte_rdy", int'(byte_rdy), m_rdy);
        chk("R3", "byte_out", int'(byte_out), m_byte);
        chk("R6", "scr_addr", int'(scr_addr), m_addr);  // also R7 R8 R10 R11
    endtask

    // Advance the model by one rising edge (R5 divider, R6..R10 address).
    task automatic model_step();
        int a, per;
        a = m_act();
        per = 80 / m_bytes();
        if (m_ph == 0) begin m_actq = a; m_lat = m_addr; end
        if (a != 0 && m_ph == 3) m_hi = int'(ram_din);
        m_rdy = (a != 0 && m_ph == 6) ? 1 : 0;
        if (m_rdy != 0) m_byte = m_hi * 16 + int'(ram_din);
        if (frame_start) begin
            m_addr = m_start(); m_ls = m_addr; m_line = 0; m_spc = 0;
        end else if (line_start) begin
            if (m_spc > 0) m_spc--;
            else if (m_line < 7) begin
                m_line++; m_addr = m_wrap(m_ls + 1); m_ls = m_addr;
            end else begin
                m_line = 0; m_addr = m_wrap(m_addr - 7); m_ls = m_addr;
                if (m_rows() == 25) m_spc = 2;
            end
        end else if (m_rdy != 0) begin
            m_addr = m_wrap(m_addr + 8);
        end
        if (m_ph == 7) m_div = (m_div + 1) % per;
        m_ph = (m_ph + 1) % 8;
    endtask

    // One cycle: inputs already set at the falling edge.
    task automatic cyc();
        ram_din = 4'($urandom);
        if (hold_noise) cpu_hold = ($urandom % 6) == 0;
        #1 compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1; cyc(); frame_start = 1'b0;
    endtask

    task automatic window(int n);
        pix_window = 1'b1;
        for (int i = 0; i < n; i++) cyc();
        pix_window = 1'b0;
        cpu_hold = 1'b0;
        cyc(); cyc();
    endtask

    task automatic next_line(int n);
        line_start = 1'b1; cyc(); line_start = 1'b0;
        cyc(); cyc(); cyc();
        window(n);
    endtask

    initial begin
        automatic int mlist[8] = '{6, 0, 3, 4, 1, 2, 5, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R1 R10: reset state (phase 0, strobes idle, start of mode 6)
        chk("R10", "reset scr_addr", int'(scr_addr), 32'h6000);
        for (int k = 0; k < 8; k++) begin
            mode_sel = mlist[k];
            pulse_frame();
            hold_noise = (k % 2) == 1;
            window(45);
            // R7 R8 R9: cross two row ends, including spacing lines
            for (int l = 0; l < 20; l++) next_line(37 + l);
        end
        // R6 wrap at both divider rates, R11 via mode 7 above
        hold_noise = 0;
        mode_sel = 3'd6; pulse_frame(); window(16500);
        next_line(20);
        mode_sel = 3'd3; pulse_frame(); window(16300);
        next_line(20);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule